// File: doc/BRIEF.md
# Wake-Up Start-Up Delay Sequencer

This block controls the return from a sleep state to code execution. A wake pulse starts a sequence. The block first decides whether the restarted system clock needs time to settle, based on the sleep state being left and the selected clock source. If it does, the block counts that settling time. It then counts a fixed interrupt-entry latency. Only after both stages does it release the CPU and raise a one-cycle interrupt-routine start strobe.

The sleep state, clock source and crystal delay code are captured on the cycle of the wake pulse. The light sleep states skip the settling stage. The deep states wait a short fixed time for an RC or external clock, and a selectable, much longer time for a crystal. A busy flag covers the whole sequence. Wake pulses that arrive during a sequence, or while the CPU is already running, are ignored. A sleep-entry strobe withdraws the CPU release.

Top module: `wkseq_top`

## Requirements
- R1: After a synchronous reset, `cpu_run_o`, `isr_start_o` and `busy_o` are all low.
- R2: Light sleep states skip the settling stage: mode code 0 (idle), 1 (extended standby) and 3 (standby). With any clock source, `isr_start_o` is high in the cycle after clock edge number 13, counting the edge that samples `wake_i` as edge 0.
- R3: Deep sleep states are mode code 2 (power save), 4 (power down) and reserved codes 5 to 7. From a deep state, with clock source code 00 or 01 (internal RC) or 10 (external clock), the settling stage is 6 cycles and `isr_start_o` follows at edge 6+13.
- R4: From a deep state with clock source code 11 (crystal), the settling stage length comes from `xtal_sel_i`: 00 = 256, 01 = 1000, 10 = 4000, 11 = 16000 cycles. `isr_start_o` follows at edge delay+13.
- R5: `busy_o` goes high after edge 0 and stays high until the edge that raises `isr_start_o`, where it drops.
- R6: `isr_start_o` is high for exactly one cycle, and `cpu_run_o` rises on the same edge.
- R7: `cpu_run_o` stays high until `sleep_i` is sampled high, and then goes low. `sleep_i` has no effect while the CPU is not released.
- R8: A wake pulse that arrives while `busy_o` is high is ignored. It produces no second `isr_start_o` and does not change the timing of the running sequence.
- R9: A wake pulse that arrives while `cpu_run_o` is high is ignored. `busy_o` stays low and no `isr_start_o` follows.
- R10: `prev_mode_i`, `clk_src_i` and `xtal_sel_i` are sampled only on edge 0. Changing them during a sequence does not alter its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_i | input | 1 | Wake request pulse |
| sleep_i | input | 1 | Sleep entry strobe; withdraws CPU release |
| prev_mode_i | input | 3 | Sleep state being left (codes as in R2/R3) |
| clk_src_i | input | 2 | System clock source code |
| xtal_sel_i | input | 2 | Crystal settling length code |
| cpu_run_o | output | 1 | CPU released |
| isr_start_o | output | 1 | One-cycle interrupt routine start strobe |
| busy_o | output | 1 | Wake sequence in progress |

## Verification
The bench builds the block with its default parameters: a 6-cycle RC settle, a 13-cycle entry latency, and crystal lengths of 256, 1000, 4000 and 16000. With these values, the real 16000-cycle crystal wait and the counter width it needs are exercised, not a scaled-down version. With all four crystal codes plus the bypass and RC cases taking about 22k cycles, every mode and source combination can be checked for exact cycle timing. Late wake pulses and input changes in the middle of a sequence are then compared against the same timing.

// File: rtl/wkseq_pkg.sv
package wkseq_pkg;

  typedef enum logic [1:0] {
    S_SLEEP = 2'd0,
    S_STAB  = 2'd1,
    S_LAT   = 2'd2,
    S_RUN   = 2'd3
  } seq_state_t;

  localparam logic [2:0] MODE_IDLE   = 3'd0;
  localparam logic [2:0] MODE_XSTBY  = 3'd1;
  localparam logic [2:0] MODE_SAVE   = 3'd2;
  localparam logic [2:0] MODE_STBY   = 3'd3;
  localparam logic [2:0] MODE_DOWN   = 3'd4;

  localparam logic [1:0] SRC_XTAL    = 2'b11;

  function automatic logic is_light_mode(input logic [2:0] m);
    return (m == MODE_IDLE) || (m == MODE_XSTBY) || (m == MODE_STBY);
  endfunction

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int r;
    r = a;
    if (b > r) r = b;
    if (c > r) r = c;
    if (d > r) r = d;
    return r;
  endfunction

endpackage

// File: rtl/wkseq_delay_sel.sv
module wkseq_delay_sel
  import wkseq_pkg::*;
#(
  parameter int RC_CYC = 6,
  parameter int XT0    = 256,
  parameter int XT1    = 1000,
  parameter int XT2    = 4000,
  parameter int XT3    = 16000,
  parameter int CW     = 14
) (
  input  logic [2:0]    mode_i,
  input  logic [1:0]    src_i,
  input  logic [1:0]    xsel_i,
  output logic [CW-1:0] dly_o
);

  localparam int NXT = 4;
  localparam int XT_TAB [NXT] = '{XT0, XT1, XT2, XT3};

  logic [CW-1:0] xt_len [NXT];
  logic [CW-1:0] xt_pick;

  genvar gi;
  generate
    for (gi = 0; gi < NXT; gi++) begin : g_xt
      assign xt_len[gi] = CW'(XT_TAB[gi]);
    end
  endgenerate

  always_comb begin
    xt_pick = xt_len[xsel_i];
  end

  always_comb begin
    if (is_light_mode(mode_i)) begin
      dly_o = '0;
    end else if (src_i == SRC_XTAL) begin
      dly_o = xt_pick;
    end else begin
      dly_o = CW'(RC_CYC);
    end
  end

endmodule

// File: rtl/wkseq_counter.sv
module wkseq_counter #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (dec_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  // R3/R4: the stage counter is never stepped below zero
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !load_i) |-> !zero_o);

endmodule

// File: rtl/wkseq_ctrl.sv
module wkseq_ctrl
  import wkseq_pkg::*;
#(
  parameter int LAT_CYC = 13,
  parameter int CW      = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wake_i,
  input  logic          sleep_i,
  input  logic [CW-1:0] dly_i,
  input  logic          zero_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          dec_o,
  output logic          cpu_run_o,
  output logic          isr_start_o,
  output logic          busy_o
);

  localparam logic [CW-1:0] LAT_LOAD = CW'(LAT_CYC - 1);

  seq_state_t state_q, state_d;
  logic       run_q, isr_q, busy_q;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    dec_o      = 1'b0;
    unique case (state_q)
      S_SLEEP: begin
        if (wake_i) begin
          load_o = 1'b1;
          if (dly_i == '0) begin
            state_d    = S_LAT;
            load_val_o = LAT_LOAD;
          end else begin
            state_d    = S_STAB;
            load_val_o = dly_i - 1'b1;
          end
        end
      end
      S_STAB: begin
        if (zero_i) begin
          state_d    = S_LAT;
          load_o     = 1'b1;
          load_val_o = LAT_LOAD;
        end else begin
          dec_o = 1'b1;
        end
      end
      S_LAT: begin
        if (zero_i) begin
          state_d = S_RUN;
        end else begin
          dec_o = 1'b1;
        end
      end
      S_RUN: begin
        if (sleep_i) begin
          state_d = S_SLEEP;
        end
      end
      default: state_d = S_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_SLEEP;
      run_q   <= 1'b0;
      isr_q   <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= (state_d == S_RUN);
      isr_q   <= (state_q == S_LAT) && zero_i;
      busy_q  <= (state_d == S_STAB) || (state_d == S_LAT);
    end
  end

  assign cpu_run_o   = run_q;
  assign isr_start_o = isr_q;
  assign busy_o      = busy_q;

  // R6: the routine start strobe lasts one cycle
  p_isr_single_r6: assert property (@(posedge clk) disable iff (rst)
    isr_q |=> !isr_q);

  // R6/R5: the strobe comes with the CPU release and ends busy
  p_isr_release_r5: assert property (@(posedge clk) disable iff (rst)
    isr_q |-> (run_q && !busy_q));

  // R5: a sequence only starts from a wake request
  p_busy_from_wake_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(wake_i));

  // R7: the CPU release is only withdrawn by a sleep entry
  p_run_hold_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> $past(sleep_i));

  // R5: the CPU stays held while a sequence runs
  p_hold_while_busy_r5: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !run_q);

  // R9: no sequence starts while the CPU is released
  p_no_wake_running_r9: assert property (@(posedge clk) disable iff (rst)
    run_q && !sleep_i |=> !busy_q);

endmodule

// File: rtl/wkseq_top.sv
module wkseq_top
  import wkseq_pkg::*;
#(
  parameter int RC_CYC  = 6,
  parameter int LAT_CYC = 13,
  parameter int XT0     = 256,
  parameter int XT1     = 1000,
  parameter int XT2     = 4000,
  parameter int XT3     = 16000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wake_i,
  input  logic       sleep_i,
  input  logic [2:0] prev_mode_i,
  input  logic [1:0] clk_src_i,
  input  logic [1:0] xtal_sel_i,
  output logic       cpu_run_o,
  output logic       isr_start_o,
  output logic       busy_o
);

  localparam int MAX_XT  = max_of4(XT0, XT1, XT2, XT3);
  localparam int MAX_ALL = max_of4(MAX_XT, RC_CYC, LAT_CYC, 1);
  localparam int CW      = $clog2(MAX_ALL + 1);

  logic [CW-1:0] dly;
  logic          load, dec, zero;
  logic [CW-1:0] load_val;

  wkseq_delay_sel #(
    .RC_CYC(RC_CYC), .XT0(XT0), .XT1(XT1), .XT2(XT2), .XT3(XT3), .CW(CW)
  ) u_sel (
    .mode_i (prev_mode_i),
    .src_i  (clk_src_i),
    .xsel_i (xtal_sel_i),
    .dly_o  (dly)
  );

  wkseq_counter #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .load_val_i (load_val),
    .dec_i      (dec),
    .zero_o     (zero)
  );

  wkseq_ctrl #(.LAT_CYC(LAT_CYC), .CW(CW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wake_i      (wake_i),
    .sleep_i     (sleep_i),
    .dly_i       (dly),
    .zero_i      (zero),
    .load_o      (load),
    .load_val_o  (load_val),
    .dec_o       (dec),
    .cpu_run_o   (cpu_run_o),
    .isr_start_o (isr_start_o),
    .busy_o      (busy_o)
  );

endmodule

// File: tb/wkseq_top_tb.sv
`timescale 1ns/1ps
module wkseq_top_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wake = 1'b0;
  logic       slp = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [1:0] src = 2'd0;
  logic [1:0] xsel = 2'd0;
  logic       cpu_run, isr_start, busy;

  int    cyc = 0;
  int    n_tests = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  bit    isr_prev = 1'b0;
  int    q_exp[$];
  string q_tag[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wkseq_top u_dut (
    .clk(clk), .rst(rst), .wake_i(wake), .sleep_i(slp),
    .prev_mode_i(mode), .clk_src_i(src), .xtal_sel_i(xsel),
    .cpu_run_o(cpu_run), .isr_start_o(isr_start), .busy_o(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [2:0] m, input logic [1:0] s, input logic [1:0] x);
    int d;
    if (m == 3'd0 || m == 3'd1 || m == 3'd3) d = 0;
    else if (s == 2'b11) begin
      case (x)
        2'b00: d = 256;
        2'b01: d = 1000;
        2'b10: d = 4000;
        default: d = 16000;
      endcase
    end else d = 6;
    return d + 13;
  endfunction

  // monitor: compares each strobe against the scoreboard queue
  always @(negedge clk) begin
    if (!rst) begin
      if (isr_start) begin
        if (q_exp.size() == 0) begin
          check(1'b0, "R8/R9 unexpected isr_start", cyc, -1);
        end else begin
          int    e;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          check(cyc == e, t, cyc, e);
          check(cpu_run == 1'b1, "R6 cpu_run with isr_start", int'(cpu_run), 1);
          check(busy == 1'b0, "R5 busy low at isr_start", int'(busy), 0);
        end
        check(!isr_prev, "R6 isr_start single cycle", int'(isr_prev), 0);
      end
      isr_prev = isr_start;
    end
  end

  task automatic go_sleep();
    @(negedge clk);
    slp = 1'b1;
    @(negedge clk);
    slp = 1'b0;
    check(cpu_run == 1'b0, "R7 cpu_run dropped by sleep_i", int'(cpu_run), 0);
  endtask

  // driver: launches a wake and pushes the expected strobe cycle
  task automatic wake_seq(input logic [2:0] m, input logic [1:0] s, input logic [1:0] x,
                          input string tag, input bit disturb);
    if (cpu_run) go_sleep();
    @(negedge clk);
    mode = m; src = s; xsel = x; wake = 1'b1;
    q_exp.push_back(cyc + 1 + exp_len(m, s, x));
    q_tag.push_back(tag);
    @(negedge clk);
    wake = 1'b0;
    check(busy == 1'b1, "R5 busy after wake", int'(busy), 1);
    if (disturb) begin
      // R8/R10: late wake and changed selects must not matter
      repeat (3) @(negedge clk);
      wake = 1'b1; mode = 3'd0; src = 2'b11; xsel = 2'b11;
      @(negedge clk);
      wake = 1'b0;
    end
    for (int i = 0; i < 20000 && !cpu_run; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    check(q_exp.size() == 0, "R2/R3/R4 strobe seen", q_exp.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cpu_run == 1'b0, "R1 reset cpu_run", int'(cpu_run), 0);
    check(isr_start == 1'b0, "R1 reset isr_start", int'(isr_start), 0);
    check(busy == 1'b0, "R1 reset busy", int'(busy), 0);

    // R7: sleep strobe while not released has no effect
    slp = 1'b1; @(negedge clk); slp = 1'b0; @(negedge clk);
    check(cpu_run == 1'b0 && busy == 1'b0, "R7 sleep while asleep", int'(cpu_run), 0);

    wake_seq(3'd0, 2'b00, 2'b00, "R2 idle bypass", 1'b0);
    wake_seq(3'd1, 2'b11, 2'b11, "R2 ext standby crystal bypass", 1'b0);
    wake_seq(3'd3, 2'b10, 2'b00, "R2 standby bypass", 1'b0);
    wake_seq(3'd2, 2'b00, 2'b00, "R3 power save rc", 1'b0);
    wake_seq(3'd4, 2'b01, 2'b11, "R3 power down rc", 1'b0);
    wake_seq(3'd4, 2'b10, 2'b00, "R3 power down ext clock", 1'b0);
    wake_seq(3'd6, 2'b00, 2'b00, "R3 reserved mode deep", 1'b0);
    wake_seq(3'd2, 2'b11, 2'b00, "R4 crystal 256", 1'b0);
    wake_seq(3'd4, 2'b11, 2'b01, "R4 crystal 1000", 1'b0);
    wake_seq(3'd2, 2'b11, 2'b10, "R4 crystal 4000", 1'b0);
    wake_seq(3'd4, 2'b11, 2'b11, "R4 crystal 16000", 1'b0);
    wake_seq(3'd4, 2'b00, 2'b00, "R8 R10 late wake ignored", 1'b1);
    wake_seq(3'd2, 2'b11, 2'b00, "R10 selects sampled once", 1'b1);

    // R9: wake while running is ignored
    @(negedge clk); wake = 1'b1; @(negedge clk); wake = 1'b0;
    repeat (30) @(negedge clk);
    check(busy == 1'b0, "R9 no busy while running", int'(busy), 0);
    check(cpu_run == 1'b1, "R9 still running", int'(cpu_run), 1);
    check(q_exp.size() == 0, "R9 no extra strobe", q_exp.size(), 0);

    go_sleep();
    repeat (5) @(negedge clk);
    check(cpu_run == 1'b0, "R7 stays asleep", int'(cpu_run), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule